// File: doc/BRIEF.md
# 48-to-64-bit word packing buffer

This block sits between a producer of 48-bit words and a consumer that takes 128-bit beats, each made of two 64-bit words. Incoming words are treated as one continuous bit stream and repacked into 64-bit words with no gaps, so every four input words yield exactly three output words. The packed words wait in an internal word store. This lets the faster side run ahead in bursts while the slower side catches up.

Both sides use valid/ready handshakes. A beat is offered only once two complete packed words are stored. A flush request closes the current stream. The last partial word is filled out with zeros, and a zero word is added if needed so that the final beat is whole. That final beat carries a last flag. The storage depth is a parameter. The full-size setting is 8192 packed words, and a small value is used in simulation.

Top module: `pk48_buffer`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `out_last` and `flushing` are 0.
- R2: Input word j, bit i, is stream bit 48*j+i (least significant first). Packed word m holds stream bits 64*m to 64*m+63. Beat b carries packed word 2*b in `out_data[63:0]` and word 2*b+1 in `out_data[127:64]`.
- R3: `out_valid` is 1 only while at least two packed words are stored. Each accepted beat removes exactly two words.
- R4: `in_ready` is 0 when the offered word would complete a packed word and the store already holds `DEPTH` words. With `DEPTH`=16 and the output stalled from an empty, word-aligned start, exactly 22 input words are accepted.
- R5: A flush fills the unused upper bits of a partial packed word with zeros and stores that word.
- R6: If the stored word count is then odd, the flush adds one all-zero word. The beat that holds the final word of the flushed stream has `out_last`=1.
- R7: A flush when the stream length since the previous beat boundary is a multiple of 128 bits stores nothing, and no beat is marked.
- R8: `flushing` is 1 from the cycle after a flush is taken until its padding is stored. `in_ready` is 0 while `flush_req` or `flushing` is 1. A flush is taken in a cycle where `flush_req`=1 and `flushing`=0.
- R9: While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid`=1 and holds `out_data` and `out_last` unchanged.
- R10: `out_last` is 0 on every beat that does not close a flushed stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_data | input | IN_W (48) | Input word |
| in_ready | output | 1 | Input word accepted this cycle if valid |
| flush_req | input | 1 | Request to close the stream with zero padding |
| flushing | output | 1 | Flush padding still in progress |
| out_valid | output | 1 | Beat of two packed words offered |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 2*WORD_W (128) | Beat; lower-addressed word in the low half |
| out_last | output | 1 | Beat closes a flushed stream |

## Verification
The bench compares every beat against a bit-queue model of the stream. The word and flag checks are run under several input patterns:
- A sweep of 0 to 9 words followed by a flush reaches every partial-word fill level (0, 16, 32 and 48 bits) with both word-count parities. This separates tail padding from pair padding and from the case where a flush does nothing.
- Each sweep is repeated under throttled handshakes. This shows that data order does not depend on timing.
- A stalled-output burst fills the store. This pins down the exact input count at which the input stalls, and it shows that the offered beat holds steady while stalled.
- Long random streams, with and without a flush and with random rates on both sides, exercise wrap-around of the store and many fill and parity combinations.

// File: rtl/pk48_pkg.sv
package pk48_pkg;

  typedef enum logic [1:0] {
    FL_IDLE = 2'd0,
    FL_TAIL = 2'd1,
    FL_PAD  = 2'd2
  } flush_st_e;

  // Does a fill of `fill` bits plus one input word complete a packed word?
  function automatic bit pk_completes(int fill, int in_w, int word_w);
    return (fill + in_w) >= word_w;
  endfunction

  // Fill left over after one input word has been merged.
  function automatic int pk_next_fill(int fill, int in_w, int word_w);
    int sum;
    sum = fill + in_w;
    return (sum >= word_w) ? sum - word_w : sum;
  endfunction

endpackage

// File: rtl/pk48_packer.sv
module pk48_packer
  import pk48_pkg::*;
#(
  parameter int IN_W   = 48,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  output logic              in_ready,
  input  logic              flush_req,
  output logic              flushing,
  input  logic              room,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic              push_last
);

  localparam int WW = IN_W + WORD_W;
  localparam int FW = $clog2(WW);

  logic [WORD_W-1:0] hold_q;
  logic [FW-1:0]     fill_q;
  logic              odd_q;
  flush_st_e         st_q;

  logic [WW-1:0] merged;
  logic [FW-1:0] fill_sum;
  logic          emits;
  logic          in_take;
  logic          tail_nonempty;

  assign merged        = WW'(hold_q) | (WW'(in_data) << fill_q);
  assign fill_sum      = fill_q + FW'(IN_W);
  assign emits         = (fill_sum >= FW'(WORD_W));
  assign tail_nonempty = (fill_q != '0);

  assign in_ready = (st_q == FL_IDLE) && !flush_req && (!emits || room);
  assign in_take  = in_valid && in_ready;
  assign flushing = (st_q != FL_IDLE);

  always_comb begin
    push      = 1'b0;
    push_data = '0;
    push_last = 1'b0;
    unique case (st_q)
      FL_IDLE: begin
        if (in_take && emits) begin
          push      = 1'b1;
          push_data = merged[WORD_W-1:0];
        end
      end
      FL_TAIL: begin
        if (tail_nonempty) begin
          push      = room;
          push_data = hold_q;
          push_last = odd_q;
        end else if (odd_q) begin
          push      = room;
          push_last = 1'b1;
        end
      end
      FL_PAD: begin
        push      = room;
        push_last = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      fill_q <= '0;
      odd_q  <= 1'b0;
      st_q   <= FL_IDLE;
    end else begin
      if (push) odd_q <= ~odd_q;
      unique case (st_q)
        FL_IDLE: begin
          if (flush_req) begin
            st_q <= FL_TAIL;
          end else if (in_take) begin
            if (emits) begin
              hold_q <= WORD_W'(merged >> WORD_W);
              fill_q <= fill_sum - FW'(WORD_W);
            end else begin
              hold_q <= merged[WORD_W-1:0];
              fill_q <= fill_sum;
            end
          end
        end
        FL_TAIL: begin
          if (tail_nonempty) begin
            if (room) begin
              hold_q <= '0;
              fill_q <= '0;
              st_q   <= odd_q ? FL_IDLE : FL_PAD;
            end
          end else if (!odd_q || room) begin
            st_q <= FL_IDLE;
          end
        end
        FL_PAD: begin
          if (room) st_q <= FL_IDLE;
        end
        default: st_q <= FL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pk48_fifo.sv
module pk48_fifo #(
  parameter int W     = 65,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_two,
  output logic [W-1:0]             head_lo,
  output logic [W-1:0]             head_hi,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] level_q;

  assign level   = level_q;
  assign full    = (level_q == LW'(DEPTH));
  assign head_lo = mem[rd_ptr];
  assign head_hi = mem[rd_ptr + AW'(1)];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (wr_en)  wr_ptr <= wr_ptr + AW'(1);
      if (rd_two) rd_ptr <= rd_ptr + AW'(2);
      level_q <= level_q + (wr_en ? LW'(1) : LW'(0)) - (rd_two ? LW'(2) : LW'(0));
    end
  end

endmodule

// File: rtl/pk48_beat.sv
module pk48_beat #(
  parameter int WORD_W = 64,
  parameter int LW     = 5
) (
  input  logic [LW-1:0]       level,
  input  logic [WORD_W:0]     head_lo,
  input  logic [WORD_W:0]     head_hi,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [2*WORD_W-1:0] out_data,
  output logic                out_last,
  output logic                pop
);

  assign out_valid = (level >= LW'(2));
  assign out_data  = {head_hi[WORD_W-1:0], head_lo[WORD_W-1:0]};
  assign out_last  = out_valid && (head_hi[WORD_W] || head_lo[WORD_W]);
  assign pop       = out_valid && out_ready;

endmodule

// File: rtl/pk48_buffer.sv
module pk48_buffer #(
  parameter int IN_W   = 48,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [IN_W-1:0]     in_data,
  output logic                in_ready,
  input  logic                flush_req,
  output logic                flushing,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*WORD_W-1:0] out_data,
  output logic                out_last
);

  localparam int LW = $clog2(DEPTH) + 1;

  logic              word_push;
  logic [WORD_W-1:0] word_data;
  logic              word_last;
  logic              word_full;
  logic [LW-1:0]     word_level;
  logic [WORD_W:0]   head_lo;
  logic [WORD_W:0]   head_hi;
  logic              beat_pop;

  pk48_packer #(.IN_W(IN_W), .WORD_W(WORD_W)) i_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .flush_req (flush_req),
    .flushing  (flushing),
    .room      (!word_full),
    .push      (word_push),
    .push_data (word_data),
    .push_last (word_last)
  );

  pk48_fifo #(.W(WORD_W + 1), .DEPTH(DEPTH)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (word_push),
    .wr_data ({word_last, word_data}),
    .rd_two  (beat_pop),
    .head_lo (head_lo),
    .head_hi (head_hi),
    .level   (word_level),
    .full    (word_full)
  );

  pk48_beat #(.WORD_W(WORD_W), .LW(LW)) i_beat (
    .level     (word_level),
    .head_lo   (head_lo),
    .head_hi   (head_hi),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .pop       (beat_pop)
  );

endmodule

// File: rtl/pk48_buffer_chk.sv
module pk48_buffer_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5,
  parameter int OW    = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          flushing,
  input logic          flush_req,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          out_last,
  input logic          word_push,
  input logic [LW-1:0] word_level,
  input logic          beat_pop
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> (word_level < LW'(DEPTH)));  // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    beat_pop |-> (word_level >= LW'(2)));  // R3

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));  // R9

  AST_FLUSH_GATES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (flushing || flush_req) |-> !in_ready);  // R8

endmodule

bind pk48_buffer pk48_buffer_chk #(.DEPTH(DEPTH), .LW(LW), .OW(2*WORD_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .flushing   (flushing),
  .flush_req  (flush_req),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .word_push  (word_push),
  .word_level (word_level),
  .beat_pop   (beat_pop)
);

// File: tb/test_pk48_buffer.sv
`timescale 1ns/1ps
module test_pk48_buffer;

  localparam int IN_W   = 48;
  localparam int WORD_W = 64;
  localparam int DEPTH  = 16;
  localparam int OW     = 2*WORD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic            in_ready;
  logic            flush_req = 1'b0;
  logic            flushing;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [OW-1:0]   out_data;
  logic            out_last;

  pk48_buffer #(.IN_W(IN_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) i_pk48_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .flush_req(flush_req), .flushing(flushing),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  int total = 0;
  int bad = 0;
  bit expq[$];
  longint marks[$];
  longint stream_bits = 0;
  longint consumed = 0;
  int sent = 0;
  int words_left = 0;
  int in_rate = 100;
  int out_rate = 100;
  bit want_flush = 1'b0;

  task automatic chk(bit ok, string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_word(logic [IN_W-1:0] w);
    for (int i = 0; i < IN_W; i++) expq.push_back(w[i]);
    stream_bits += IN_W;
  endtask

  // Closing a stream pads to the next 128-bit boundary; nothing if aligned.
  task automatic model_flush();
    longint pad;
    pad = (OW - (stream_bits % OW)) % OW;
    if (pad != 0) begin
      for (longint i = 0; i < pad; i++) expq.push_back(1'b0);
      stream_bits += pad;
      marks.push_back(stream_bits);
    end
  endtask

  task automatic check_beat();
    logic [OW-1:0] e;
    bit el;
    if (expq.size() < OW) begin
      chk(1'b0, "R3 beat offered without two words", OW'(out_valid), '0);
      return;
    end
    e = '0;
    for (int i = 0; i < OW; i++) e[i] = expq.pop_front();
    consumed += OW;
    el = (marks.size() > 0) && (marks[0] == consumed);
    if (el) void'(marks.pop_front());
    chk(out_data === e, "R2 R5 R6 beat data", out_data, e);
    chk(out_last === el, "R6 R10 last flag", OW'(out_last), OW'(el));
  endtask

  task automatic cycle();
    bit took_in;
    bit took_fl;
    @(negedge clk);
    took_in = in_valid && in_ready;
    took_fl = flush_req && !flushing;
    if (flushing) chk(!in_ready, "R8 input blocked while flushing", OW'(in_ready), '0);
    if (took_in) begin
      model_word(in_data);
      sent++;
    end
    if (took_fl) model_flush();
    if (out_valid && out_ready) check_beat();
    @(posedge clk);
    #1;
    if (took_in) in_valid = 1'b0;
    if (took_fl) flush_req = 1'b0;
    if (!in_valid && words_left > 0 && !flush_req && int'($urandom % 100) < in_rate) begin
      in_valid = 1'b1;
      in_data  = IN_W'({$urandom, $urandom});
      words_left--;
    end
    if (want_flush && words_left == 0 && !in_valid && !flush_req && !took_fl) begin
      flush_req  = 1'b1;
      want_flush = 1'b0;
    end
    out_ready = int'($urandom % 100) < out_rate;
  endtask

  task automatic run_seq(int n, bit fl, int ir, int orr);
    int guard;
    words_left = n;
    want_flush = fl;
    in_rate = ir;
    out_rate = orr;
    guard = 0;
    while ((words_left > 0 || in_valid || want_flush || flush_req || flushing ||
            expq.size() >= OW) && guard < 20000) begin
      cycle();
      guard++;
    end
    if (guard >= 20000) chk(1'b0, "R3 stream did not drain", '0, '1);
    for (int k = 0; k < 3; k++) cycle();
    @(negedge clk);
    chk(!out_valid, "R7 no beat without two stored words", OW'(out_valid), '0);
    if (fl) chk(expq.size() == 0, "R5 flush leaves no partial data", OW'(expq.size()), '0);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [OW-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 reset in_ready", OW'(in_ready), OW'(1));
    chk(out_valid === 1'b0, "R1 reset out_valid", OW'(out_valid), '0);
    chk(out_last === 1'b0, "R1 reset out_last", OW'(out_last), '0);
    chk(flushing === 1'b0, "R1 reset flushing", OW'(flushing), '0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // Fill-level and parity sweep: every residue with and without an odd word.
    for (int n = 0; n < 10; n++) run_seq(n, 1'b1, 100, 100);
    for (int n = 0; n < 10; n++) run_seq(n, 1'b1, 50, 35);

    // R4 full store with output stalled; R9 beat held steady.
    sent = 0;
    words_left = 30;
    in_rate = 100;
    out_rate = 0;
    for (int k = 0; k < 40; k++) cycle();
    held = out_data;
    for (int k = 0; k < 20; k++) cycle();
    @(negedge clk);
    chk(sent == 22, "R4 words accepted into full store", OW'(sent), OW'(22));
    chk(in_ready === 1'b0, "R4 input stalled when full", OW'(in_ready), '0);
    chk(out_valid === 1'b1, "R9 beat still offered", OW'(out_valid), OW'(1));
    chk(out_data === held, "R9 beat data held", out_data, held);
    run_seq(words_left, 1'b1, 100, 100);

    // Random streams and rates.
    for (int k = 0; k < 30; k++)
      run_seq(1 + int'($urandom % 120), bit'($urandom % 2),
              30 + int'($urandom % 71), 20 + int'($urandom % 81));
    run_seq(7, 1'b1, 70, 60);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule